// File: doc/BRIEF.md
# Test Clock and Stimulus Source Selector

This block sits at the front of an on-chip memory test harness. It decides which clock runs the harness and which source feeds the memory under test. A two-bit clock-select code picks one of three incoming clocks: a clock bit toggled through the logic-analyzer probe bank, a clock pin on the general-purpose I/O, or the system bus clock. A separate one-bit mode input decides whether the memory chip-select, write-enable, write mask, address and write data come from the bus adapter or from the fields of the scanned-in test packet.

The chosen clock leaves the block on `harness_clk`. Every memory control and data output is launched from a register clocked by that clock, so the memory sees clean, aligned stimulus one harness edge after the selected source presents it. Read data returning from the memory is registered into two separate copies, one for the packet register and one for the bus adapter, in both modes. The selection inputs are only changed while `rst` is held high. Switching without glitches is left to the surrounding logic.

Top module: `tclk_mode_sel`

## Requirements
- R1: With `clk_sel` = 2'b00, `harness_clk` follows `la_clk`, and the other two clocks have no effect on it.
- R2: With `clk_sel` = 2'b01, `harness_clk` follows `gpio_clk`.
- R3: With `clk_sel` = 2'b10, `harness_clk` follows `bus_clk`.
- R4: The unused code `clk_sel` = 2'b11 falls back to `bus_clk`.
- R5: A rising `harness_clk` edge with `rst` high sets `sram_csb` = 1, `sram_web` = 1, and `sram_wmask`, `sram_addr`, `sram_wdata`, `pkt_rdata` and `bus_rdata` to zero (synchronous, active-high reset).
- R6: With `bus_mode` = 1 and `rst` low, each rising `harness_clk` edge copies `bus_csb`, `bus_web`, `bus_wmask`, `bus_addr` and `bus_wdata` onto the matching `sram_*` outputs, visible right after that edge.
- R7: With `bus_mode` = 0 and `rst` low, each rising `harness_clk` edge copies `pkt_csb`, `pkt_web`, `pkt_wmask`, `pkt_addr` and `pkt_wdata` onto the `sram_*` outputs.
- R8: In either mode, each rising `harness_clk` edge with `rst` low copies `sram_rdata` onto both `pkt_rdata` and `bus_rdata`.
- R9: The stimulus fields of the source that is not selected have no effect on the `sram_*` outputs.
- R10: Edges on a clock input that is not selected do not update any registered output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled on `harness_clk` |
| clk_sel | input | 2 | Clock source code: 00 probe bit, 01 I/O pin, 10 or 11 bus clock |
| bus_mode | input | 1 | 1 takes stimulus from the bus adapter, 0 from the test packet |
| la_clk | input | 1 | Clock bit from the logic-analyzer probe bank |
| gpio_clk | input | 1 | Clock from a general-purpose I/O pin |
| bus_clk | input | 1 | System bus clock |
| bus_csb | input | 1 | Bus-side memory chip select, active low |
| bus_web | input | 1 | Bus-side memory write enable, active low |
| bus_wmask | input | MASK_W | Bus-side write byte mask |
| bus_addr | input | ADDR_W | Bus-side memory address |
| bus_wdata | input | DATA_W | Bus-side write data |
| pkt_csb | input | 1 | Packet-side chip select, active low |
| pkt_web | input | 1 | Packet-side write enable, active low |
| pkt_wmask | input | MASK_W | Packet-side write byte mask |
| pkt_addr | input | ADDR_W | Packet-side address |
| pkt_wdata | input | DATA_W | Packet-side write data |
| sram_rdata | input | DATA_W | Read data returned by the memory under test |
| harness_clk | output | 1 | Selected harness clock |
| sram_csb | output | 1 | Registered chip select to the memory |
| sram_web | output | 1 | Registered write enable to the memory |
| sram_wmask | output | MASK_W | Registered write mask to the memory |
| sram_addr | output | ADDR_W | Registered address to the memory |
| sram_wdata | output | DATA_W | Registered write data to the memory |
| pkt_rdata | output | DATA_W | Registered read data copy for the packet register |
| bus_rdata | output | DATA_W | Registered read data copy for the bus adapter |

## Verification
A wrong clock route shows on `harness_clk` right away, and on the registered outputs at the very next edge of the intended clock: they either miss the update or pick it up from a clock that should be ignored. A wrong mode decode or a crossed field shows on the `sram_*` outputs right after the first harness edge that follows the stimulus, because the bench gives the bus and packet sides distinct values. A stuck or misrouted read-data register shows on either copy after one harness edge. A bad reset value shows after the first edge taken in reset.

// File: rtl/tcms_pkg.sv
package tcms_pkg;

  // Clock source codes; the bus clock also covers the spare code.
  typedef enum logic [1:0] {
    CK_PROBE = 2'b00,
    CK_PIN   = 2'b01,
    CK_BUS   = 2'b10,
    CK_SPARE = 2'b11
  } clk_src_e;

  // Read data fan-out sinks.
  localparam int SINK_PKT     = 0;
  localparam int SINK_BUS     = 1;
  localparam int NUM_RD_SINKS = 2;

endpackage

// File: rtl/tcms_clk_route.sv
module tcms_clk_route
  import tcms_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       probe_clk,
  input  logic       pin_clk,
  input  logic       sys_clk,
  output logic       clk_out
);

  // Plain selector; the source only changes while the harness is in reset.
  always_comb begin
    unique case (clk_src_e'(sel))
      CK_PROBE: clk_out = probe_clk;
      CK_PIN:   clk_out = pin_clk;
      default:  clk_out = sys_clk;
    endcase
  end

endmodule

// File: rtl/tcms_stim_mux.sv
module tcms_stim_mux #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int MASK_W = 4,
  localparam int VEC_W = 2 + MASK_W + ADDR_W + DATA_W
) (
  input  logic              use_bus,
  input  logic              b_csb,
  input  logic              b_web,
  input  logic [MASK_W-1:0] b_wmask,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              p_csb,
  input  logic              p_web,
  input  logic [MASK_W-1:0] p_wmask,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [DATA_W-1:0] p_wdata,
  output logic [VEC_W-1:0]  stim
);

  logic [VEC_W-1:0] from_bus;
  logic [VEC_W-1:0] from_pkt;

  // Layout: {csb, web, wmask, addr, wdata}
  assign from_bus = {b_csb, b_web, b_wmask, b_addr, b_wdata};
  assign from_pkt = {p_csb, p_web, p_wmask, p_addr, p_wdata};

  always_comb begin
    stim = use_bus ? from_bus : from_pkt;
  end

endmodule

// File: rtl/tcms_pipe_reg.sv
module tcms_pipe_reg #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end

endmodule

// File: rtl/tclk_mode_sel.sv
module tclk_mode_sel
  import tcms_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int MASK_W = 4
) (
  input  logic              rst,
  input  logic [1:0]        clk_sel,
  input  logic              bus_mode,
  input  logic              la_clk,
  input  logic              gpio_clk,
  input  logic              bus_clk,
  input  logic              bus_csb,
  input  logic              bus_web,
  input  logic [MASK_W-1:0] bus_wmask,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              pkt_csb,
  input  logic              pkt_web,
  input  logic [MASK_W-1:0] pkt_wmask,
  input  logic [ADDR_W-1:0] pkt_addr,
  input  logic [DATA_W-1:0] pkt_wdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              harness_clk,
  output logic              sram_csb,
  output logic              sram_web,
  output logic [MASK_W-1:0] sram_wmask,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  output logic [DATA_W-1:0] pkt_rdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int VEC_W = 2 + MASK_W + ADDR_W + DATA_W;
  // Idle memory: deselected, reading, everything else zero.
  localparam logic [VEC_W-1:0] STIM_IDLE = {2'b11, {(VEC_W-2){1'b0}}};

  logic [VEC_W-1:0]  stim_d;
  logic [VEC_W-1:0]  stim_q;
  logic [DATA_W-1:0] rd_q [NUM_RD_SINKS];

  tcms_clk_route u_route (
    .sel       (clk_sel),
    .probe_clk (la_clk),
    .pin_clk   (gpio_clk),
    .sys_clk   (bus_clk),
    .clk_out   (harness_clk)
  );

  tcms_stim_mux #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MASK_W (MASK_W)
  ) u_mux (
    .use_bus (bus_mode),
    .b_csb   (bus_csb),
    .b_web   (bus_web),
    .b_wmask (bus_wmask),
    .b_addr  (bus_addr),
    .b_wdata (bus_wdata),
    .p_csb   (pkt_csb),
    .p_web   (pkt_web),
    .p_wmask (pkt_wmask),
    .p_addr  (pkt_addr),
    .p_wdata (pkt_wdata),
    .stim    (stim_d)
  );

  tcms_pipe_reg #(
    .W       (VEC_W),
    .RST_VAL (STIM_IDLE)
  ) u_launch (
    .clk (harness_clk),
    .rst (rst),
    .d   (stim_d),
    .q   (stim_q)
  );

  assign {sram_csb, sram_web, sram_wmask, sram_addr, sram_wdata} = stim_q;

  // One private read-data register per consumer.
  for (genvar g = 0; g < NUM_RD_SINKS; g++) begin : g_rd
    tcms_pipe_reg #(
      .W       (DATA_W),
      .RST_VAL ('0)
    ) u_rd (
      .clk (harness_clk),
      .rst (rst),
      .d   (sram_rdata),
      .q   (rd_q[g])
    );
  end

  assign pkt_rdata = rd_q[SINK_PKT];
  assign bus_rdata = rd_q[SINK_BUS];

endmodule

// File: rtl/tclk_mode_sel_chk.sv
module tclk_mode_sel_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int MASK_W = 4
) (
  input logic              rst,
  input logic [1:0]        clk_sel,
  input logic              bus_mode,
  input logic              la_clk,
  input logic              gpio_clk,
  input logic              bus_clk,
  input logic              bus_csb,
  input logic              bus_web,
  input logic [MASK_W-1:0] bus_wmask,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              pkt_csb,
  input logic              pkt_web,
  input logic [MASK_W-1:0] pkt_wmask,
  input logic [ADDR_W-1:0] pkt_addr,
  input logic [DATA_W-1:0] pkt_wdata,
  input logic [DATA_W-1:0] sram_rdata,
  input logic              harness_clk,
  input logic              sram_csb,
  input logic              sram_web,
  input logic [MASK_W-1:0] sram_wmask,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_wdata,
  input logic [DATA_W-1:0] pkt_rdata,
  input logic [DATA_W-1:0] bus_rdata
);

  localparam int VEC_W = 2 + MASK_W + ADDR_W + DATA_W;

  logic [VEC_W-1:0] out_vec;
  logic [VEC_W-1:0] bus_vec;
  logic [VEC_W-1:0] pkt_vec;

  assign out_vec = {sram_csb, sram_web, sram_wmask, sram_addr, sram_wdata};
  assign bus_vec = {bus_csb, bus_web, bus_wmask, bus_addr, bus_wdata};
  assign pkt_vec = {pkt_csb, pkt_web, pkt_wmask, pkt_addr, pkt_wdata};

  // Clock routing per code, outside reset.
  always_comb begin
    if (!rst) begin
      if (clk_sel == 2'b00) begin
        a_r1_probe_clock: assert (harness_clk == la_clk)
          else $error("R1 harness clock differs from probe clock");
      end
      if (clk_sel == 2'b01) begin
        a_r2_pin_clock: assert (harness_clk == gpio_clk)
          else $error("R2 harness clock differs from pin clock");
      end
      if (clk_sel[1]) begin
        a_r3_r4_bus_clock: assert (harness_clk == bus_clk)
          else $error("R3/R4 harness clock differs from bus clock");
      end
    end
  end

  a_r6_bus_launch: assert property (@(posedge harness_clk) disable iff (rst)
    (!$past(rst) && $past(bus_mode)) |-> out_vec == $past(bus_vec))
    else $error("R6 bus stimulus not launched");

  a_r7_pkt_launch: assert property (@(posedge harness_clk) disable iff (rst)
    (!$past(rst) && !$past(bus_mode)) |-> out_vec == $past(pkt_vec))
    else $error("R7 packet stimulus not launched");

  a_r8_rdata_copies: assert property (@(posedge harness_clk) disable iff (rst)
    !$past(rst) |-> (pkt_rdata == $past(sram_rdata) && bus_rdata == $past(sram_rdata)))
    else $error("R8 read data copies wrong");

endmodule

bind tclk_mode_sel tclk_mode_sel_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .MASK_W (MASK_W)
) u_chk (.*);

// File: tb/tclk_mode_sel_test.sv
`timescale 1ns/1ps
module tclk_mode_sel_test;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int MASK_W = 4;
  localparam int ITERS  = 8;

  logic              rst = 1'b1;
  logic [1:0]        clk_sel = 2'b00;
  logic              bus_mode = 1'b0;
  logic              la_clk = 1'b0;
  logic              gpio_clk = 1'b0;
  logic              clk = 1'b0;
  logic              bus_csb, bus_web, pkt_csb, pkt_web;
  logic [MASK_W-1:0] bus_wmask, pkt_wmask;
  logic [ADDR_W-1:0] bus_addr, pkt_addr;
  logic [DATA_W-1:0] bus_wdata, pkt_wdata, sram_rdata;
  logic              harness_clk, sram_csb, sram_web;
  logic [MASK_W-1:0] sram_wmask;
  logic [ADDR_W-1:0] sram_addr;
  logic [DATA_W-1:0] sram_wdata, pkt_rdata, bus_rdata;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz, also the bus clock

  tclk_mode_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) uut (
    .rst, .clk_sel, .bus_mode, .la_clk, .gpio_clk, .bus_clk(clk),
    .bus_csb, .bus_web, .bus_wmask, .bus_addr, .bus_wdata,
    .pkt_csb, .pkt_web, .pkt_wmask, .pkt_addr, .pkt_wdata,
    .sram_rdata, .harness_clk, .sram_csb, .sram_web, .sram_wmask,
    .sram_addr, .sram_wdata, .pkt_rdata, .bus_rdata
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack(input logic c, input logic w,
      input logic [MASK_W-1:0] m, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    return 64'({c, w, m, a, d});
  endfunction

  function automatic logic [63:0] out_now();
    return pack(sram_csb, sram_web, sram_wmask, sram_addr, sram_wdata);
  endfunction

  // One edge of the selected clock; returns just after it.
  task automatic pulse(input logic [1:0] s);
    if (s == 2'b00) begin
      #1 la_clk = 1'b1; #2 la_clk = 1'b0; #1;
    end else if (s == 2'b01) begin
      #1 gpio_clk = 1'b1; #2 gpio_clk = 1'b0; #1;
    end else begin
      @(posedge clk); #1;
    end
  endtask

  function automatic string clk_req(input logic [1:0] s);
    case (s)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic start(input logic [1:0] s, input logic m);
    rst = 1'b1;
    clk_sel = s;
    bus_mode = m;
    sram_rdata = '1;
    pulse(s);
    pulse(s);
    check("R5 stimulus reset", out_now(), pack(1'b1, 1'b1, '0, '0, '0));
    check("R5 read data reset", {pkt_rdata, bus_rdata}, 64'd0);
    // clock routing, checked while still in reset
    if (s[1]) begin
      @(posedge clk); #1;
      check(clk_req(s), 64'(harness_clk), 64'd1);
      @(negedge clk); #1;
      check(clk_req(s), 64'(harness_clk), 64'd0);
    end else begin
      @(posedge clk); #1;
      check(clk_req(s), 64'(harness_clk), 64'd0);  // bus clock high, not routed
      if (s == 2'b00) la_clk = 1'b1; else gpio_clk = 1'b1;
      #0.5 check(clk_req(s), 64'(harness_clk), 64'd1);
      la_clk = 1'b0; gpio_clk = 1'b0;
      #0.5 check(clk_req(s), 64'(harness_clk), 64'd0);
    end
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 2; m++) begin
        start(2'(s), 1'(m));
        for (int i = 0; i < ITERS; i++) begin
          logic [63:0] bexp, pexp, sel_exp;
          logic [DATA_W-1:0] rd;
          bus_csb   = i[0];
          bus_web   = i[1];
          bus_wmask = 4'(i * 3 + 1);
          bus_addr  = 8'(i * 37 + s * 11 + 5);
          bus_wdata = 32'(32'hC0DE0000 + i * 32'h00010203 + s);
          pkt_csb   = ~i[0];
          pkt_web   = i[2];
          pkt_wmask = 4'(~(i * 5));
          pkt_addr  = 8'(200 - i * 13 - s);
          pkt_wdata = 32'(32'h5A5A0000 ^ (i * 32'h01000111) ^ m);
          rd        = 32'(i * 32'h11111111 + s * 3 + m + 1);
          sram_rdata = rd;
          bexp = pack(bus_csb, bus_web, bus_wmask, bus_addr, bus_wdata);
          pexp = pack(pkt_csb, pkt_web, pkt_wmask, pkt_addr, pkt_wdata);
          sel_exp = (m == 1) ? bexp : pexp;
          pulse(2'(s));
          check((m == 1) ? "R6 bus stimulus" : "R7 packet stimulus", out_now(), sel_exp);
          check("R8 read data both copies", {pkt_rdata, bus_rdata}, {rd, rd});
          // R9: disturb only the unselected side
          if (m == 1) begin
            pkt_addr = ~pkt_addr; pkt_wdata = ~pkt_wdata; pkt_csb = ~pkt_csb;
          end else begin
            bus_addr = ~bus_addr; bus_wdata = ~bus_wdata; bus_web = ~bus_web;
          end
          pulse(2'(s));
          check("R9 unselected side ignored", out_now(), sel_exp);
          // R10: with a manual clock selected, other clocks must not update
          if (s < 2) begin
            bus_addr = ~bus_addr; pkt_addr = ~pkt_addr;
            bus_wmask = ~bus_wmask; pkt_wmask = ~pkt_wmask;
            sram_rdata = ~rd;
            repeat (3) @(posedge clk);
            #1;
            if (s == 0) begin
              #1 gpio_clk = 1'b1; #2 gpio_clk = 1'b0; #1;
            end else begin
              #1 la_clk = 1'b1; #2 la_clk = 1'b0; #1;
            end
            check("R10 stimulus held", out_now(), sel_exp);
            check("R10 read data held", {pkt_rdata, bus_rdata}, {rd, rd});
          end
        end
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule